// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block turns a small set of frame-layout settings into a stream of burst read requests that fetch a packed-pixel framebuffer one displayed line at a time. The timing generator marks the start of each frame and each active line with single-cycle strobes. Each line strobe starts the fetch of the next line. The line's bytes are cut into bursts of bus-wide beats and sent over a valid/ready request port as an address and a beat count.

All layout settings are copied into shadow registers on the frame strobe. These settings are the frame base address, the bytes fetched per line, the byte distance between line starts, the index of the last line, the burst ceiling and the limit on outstanding requests. Software can therefore rewrite the base at any time, for panning or for a buffer flip, and the change shows only from the next frame. A read-completion pulse returns one credit of the outstanding-request budget. Return data, pixel unpacking and video timing sit outside this block.

Top module: `fb_scan_addrgen`

## Requirements
- R1: After reset, and until the first frame strobe, `req_valid` stays low even when line strobes arrive.
- R2: The first burst of line 0 starts at the shadowed base address. The first burst of every later line starts exactly one pitch above the start of the line before it.
- R3: Within a line, each burst carries min(remaining beats, burst ceiling) beats. Each burst address is the previous one plus the previous beat count times BEAT_BYTES (8 bytes by default).
- R4: A line of L bytes is fetched as ceil(L / BEAT_BYTES) beats in total, and `req_valid` falls once they are all accepted.
- R5: Once the line whose index equals the programmed last-line value is complete, further line strobes issue nothing until the next frame strobe.
- R6: Configuration inputs changed after a frame strobe do not affect the current frame. They take effect at the next frame strobe.
- R7: While the number of accepted requests without a completion pulse equals the outstanding limit, `req_valid` is low. Each completion pulse frees one slot.
- R8: A line strobe that arrives while the current line is still being issued is ignored. The line continues from where it was, and no line is skipped.
- R9: A frame strobe abandons any line in progress, restarts at line 0 and drops `req_valid` in the following cycle. A line strobe in the same cycle as a frame strobe is ignored.
- R10: Once `req_valid` is high with `req_ready` low, the request stays valid with the same address and beat count until it is accepted, unless a frame strobe intervenes.
- R11: A burst-ceiling value of 0, or any value above MAX_BURST (16), is treated as MAX_BURST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | ADDR_W | Byte address of the first pixel of line 0 |
| cfg_line_len | input | LEN_W | Bytes fetched per displayed line |
| cfg_line_pitch | input | LEN_W | Byte distance between consecutive line starts |
| cfg_last_line | input | CNT_W | Number of displayed lines minus one |
| cfg_burst_max | input | BL_W | Burst ceiling in beats (0 or above MAX_BURST means MAX_BURST) |
| cfg_outst_max | input | OUT_W | Maximum outstanding requests (clamped to MAX_OUTST) |
| frame_start | input | 1 | Frame strobe from the timing generator |
| line_start | input | 1 | Active-line strobe from the timing generator |
| req_valid | output | 1 | Burst request valid |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | ADDR_W | Byte address of the burst |
| req_beats | output | BL_W | Beats in the burst |
| rd_done | input | 1 | One outstanding request has completed |

## Verification
The hardest situation to reach is a line that is partly issued and stalled on the outstanding-request budget while the timing strobes keep arriving. A stray line strobe then must not restart the line or skip ahead, and a frame strobe must discard the line cleanly. The bench withholds completion pulses so that the budget fills after a known number of accepts. It fires a line strobe into the stall and checks that the line resumes at the exact next address once completions return. In a separate run it holds `req_ready` low and fires frame strobes, first alone and then together with a line strobe. Around this, a sweep over many line lengths and every class of burst ceiling checks each burst address and length against arithmetic in the bench, while the configuration inputs are scrambled in the middle of every frame.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_LINE = 2'd1,
      SQ_DONE = 2'd2
   } seq_state_e;
endpackage

// File: rtl/fbs_shadow.sv
module fbs_shadow #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int CNT_W      = 12,
   parameter int BEAT_BYTES = 8,
   parameter int MAX_BURST  = 16,
   parameter int MAX_OUTST  = 8,
   localparam int BL_W      = $clog2(MAX_BURST + 1),
   localparam int OUT_W     = $clog2(MAX_OUTST + 1),
   localparam int BB_LG     = $clog2(BEAT_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [LEN_W-1:0]  cfg_line_len,
   input  logic [LEN_W-1:0]  cfg_line_pitch,
   input  logic [CNT_W-1:0]  cfg_last_line,
   input  logic [BL_W-1:0]   cfg_burst_max,
   input  logic [OUT_W-1:0]  cfg_outst_max,
   output logic [ADDR_W-1:0] sh_base,
   output logic [LEN_W-1:0]  sh_beats,
   output logic [LEN_W-1:0]  sh_pitch,
   output logic [CNT_W-1:0]  sh_last,
   output logic [BL_W-1:0]   sh_burst,
   output logic [OUT_W-1:0]  sh_outst
);
   logic [LEN_W-1:0] beats_in;
   logic [BL_W-1:0]  burst_in;
   logic [OUT_W-1:0] outst_in;

   // byte length to beat count, rounding a partial beat up
   generate
      if (BEAT_BYTES == 1) begin : g_byte_bus
         assign beats_in = cfg_line_len;
      end else begin : g_wide_bus
         logic [LEN_W:0] padded;
         assign padded   = {1'b0, cfg_line_len} + (LEN_W+1)'(BEAT_BYTES - 1);
         assign beats_in = LEN_W'(padded >> BB_LG);
      end
   endgenerate

   assign burst_in = (cfg_burst_max == '0 || cfg_burst_max > BL_W'(MAX_BURST))
                     ? BL_W'(MAX_BURST) : cfg_burst_max;
   assign outst_in = (cfg_outst_max > OUT_W'(MAX_OUTST)) ? OUT_W'(MAX_OUTST) : cfg_outst_max;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_base  <= '0;
         sh_beats <= '0;
         sh_pitch <= '0;
         sh_last  <= '0;
         sh_burst <= BL_W'(MAX_BURST);
         sh_outst <= '0;
      end else if (frame_start) begin
         sh_base  <= cfg_base;
         sh_beats <= beats_in;
         sh_pitch <= cfg_line_pitch;
         sh_last  <= cfg_last_line;
         sh_burst <= burst_in;
         sh_outst <= outst_in;
      end
   end
endmodule

// File: rtl/fbs_credit.sv
module fbs_credit #(
   parameter int MAX_OUTST = 8,
   localparam int OUT_W    = $clog2(MAX_OUTST + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             give,
   input  logic [OUT_W-1:0] limit,
   output logic [OUT_W-1:0] cnt,
   output logic             room
);
   logic [OUT_W-1:0] cnt_nx;

   always_comb begin
      cnt_nx = cnt;
      if (take && !give)
         cnt_nx = cnt + OUT_W'(1);
      else if (give && !take && cnt != '0)
         cnt_nx = cnt - OUT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nx;
   end

   assign room = (cnt < limit);
endmodule

// File: rtl/fbs_line_seq.sv
module fbs_line_seq
   import fbs_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int CNT_W      = 12,
   parameter int BEAT_BYTES = 8,
   parameter int MAX_BURST  = 16,
   localparam int BL_W      = $clog2(MAX_BURST + 1),
   localparam int BB_LG     = $clog2(BEAT_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              line_start,
   input  logic [ADDR_W-1:0] sh_base,
   input  logic [LEN_W-1:0]  sh_beats,
   input  logic [LEN_W-1:0]  sh_pitch,
   input  logic [CNT_W-1:0]  sh_last,
   input  logic [BL_W-1:0]   sh_burst,
   input  logic              room,
   input  logic              req_ready,
   output logic              req_valid,
   output logic [ADDR_W-1:0] req_addr,
   output logic [BL_W-1:0]   req_beats,
   output logic              accept
);
   seq_state_e        state;
   logic [CNT_W-1:0]  line_idx;
   logic [ADDR_W-1:0] line_base;
   logic [ADDR_W-1:0] cur_addr;
   logic [LEN_W-1:0]  rem;
   logic              fresh;
   logic [LEN_W-1:0]  burst_w;
   logic [ADDR_W-1:0] next_base;

   assign burst_w   = (rem < LEN_W'(sh_burst)) ? rem : LEN_W'(sh_burst);
   assign next_base = fresh ? sh_base : line_base + ADDR_W'(sh_pitch);
   assign req_valid = (state == SQ_LINE) && room;
   assign req_addr  = cur_addr;
   assign req_beats = BL_W'(burst_w);
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SQ_DONE;
         line_idx  <= '0;
         line_base <= '0;
         cur_addr  <= '0;
         rem       <= '0;
         fresh     <= 1'b0;
      end else if (frame_start) begin
         state    <= SQ_IDLE;
         line_idx <= '0;
         fresh    <= 1'b1;
         rem      <= '0;
      end else begin
         unique case (state)
            SQ_IDLE: if (line_start) begin
               line_base <= next_base;
               cur_addr  <= next_base;
               fresh     <= 1'b0;
               rem       <= sh_beats;
               if (sh_beats != '0)        state <= SQ_LINE;
               else if (line_idx == sh_last) state <= SQ_DONE;
               else                       line_idx <= line_idx + CNT_W'(1);
            end
            SQ_LINE: if (accept) begin
               cur_addr <= cur_addr + (ADDR_W'(burst_w) << BB_LG);
               rem      <= rem - burst_w;
               if (rem == burst_w) begin
                  if (line_idx == sh_last) state <= SQ_DONE;
                  else begin
                     state    <= SQ_IDLE;
                     line_idx <= line_idx + CNT_W'(1);
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/fb_scan_addrgen.sv
module fb_scan_addrgen #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int CNT_W      = 12,
   parameter int BEAT_BYTES = 8,
   parameter int MAX_BURST  = 16,
   parameter int MAX_OUTST  = 8,
   localparam int BL_W      = $clog2(MAX_BURST + 1),
   localparam int OUT_W     = $clog2(MAX_OUTST + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [LEN_W-1:0]  cfg_line_len,
   input  logic [LEN_W-1:0]  cfg_line_pitch,
   input  logic [CNT_W-1:0]  cfg_last_line,
   input  logic [BL_W-1:0]   cfg_burst_max,
   input  logic [OUT_W-1:0]  cfg_outst_max,
   input  logic              frame_start,
   input  logic              line_start,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   output logic [BL_W-1:0]   req_beats,
   input  logic              rd_done
);
   generate
      if (BEAT_BYTES < 1 || (BEAT_BYTES & (BEAT_BYTES - 1)) != 0) begin : g_bad_beat
         $error("BEAT_BYTES must be a power of two");
      end
      if (MAX_BURST < 1 || MAX_OUTST < 1) begin : g_bad_limits
         $error("MAX_BURST and MAX_OUTST must be at least one");
      end
      if (LEN_W > ADDR_W) begin : g_bad_len
         $error("LEN_W must not exceed ADDR_W");
      end
   endgenerate

   logic [ADDR_W-1:0] sh_base;
   logic [LEN_W-1:0]  sh_beats;
   logic [LEN_W-1:0]  sh_pitch;
   logic [CNT_W-1:0]  sh_last;
   logic [BL_W-1:0]   sh_burst;
   logic [OUT_W-1:0]  sh_outst;
   logic [OUT_W-1:0]  outst_cnt;
   logic              room;
   logic              accept;

   fbs_shadow #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES),
      .MAX_BURST(MAX_BURST), .MAX_OUTST(MAX_OUTST)
   ) u_shadow (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .cfg_base(cfg_base), .cfg_line_len(cfg_line_len), .cfg_line_pitch(cfg_line_pitch),
      .cfg_last_line(cfg_last_line), .cfg_burst_max(cfg_burst_max), .cfg_outst_max(cfg_outst_max),
      .sh_base(sh_base), .sh_beats(sh_beats), .sh_pitch(sh_pitch), .sh_last(sh_last),
      .sh_burst(sh_burst), .sh_outst(sh_outst)
   );

   fbs_credit #(.MAX_OUTST(MAX_OUTST)) u_credit (
      .clk(clk), .rst_n(rst_n), .take(accept), .give(rd_done),
      .limit(sh_outst), .cnt(outst_cnt), .room(room)
   );

   fbs_line_seq #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES),
      .MAX_BURST(MAX_BURST)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
      .sh_base(sh_base), .sh_beats(sh_beats), .sh_pitch(sh_pitch), .sh_last(sh_last),
      .sh_burst(sh_burst), .room(room), .req_ready(req_ready),
      .req_valid(req_valid), .req_addr(req_addr), .req_beats(req_beats), .accept(accept)
   );
endmodule

// File: rtl/fbs_scan_chk.sv
module fbs_scan_chk #(
   parameter int ADDR_W = 32,
   parameter int BL_W   = 5,
   parameter int OUT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_start,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic [BL_W-1:0]   req_beats,
   input logic              rd_done,
   input logic [BL_W-1:0]   sh_burst,
   input logic [OUT_W-1:0]  sh_outst,
   input logic [OUT_W-1:0]  outst_cnt
);
   // R10: a waiting request is held unchanged
   p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready && !frame_start) |=>
         (req_valid && $stable(req_addr) && $stable(req_beats)));

   // R3 / R11: burst size lies between one beat and the clamped ceiling
   p_burst_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_beats != '0 && req_beats <= sh_burst));

   // R7: no request offered while the budget is used up
   p_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (outst_cnt < sh_outst));

   // R7: a lone completion frees exactly one slot
   p_credit_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && !(req_valid && req_ready) && outst_cnt != '0) |=>
         (outst_cnt == $past(outst_cnt) - OUT_W'(1)));

   // R9: a frame strobe silences the request port for the next cycle
   p_frame_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !req_valid);
endmodule

bind fb_scan_addrgen fbs_scan_chk #(.ADDR_W(ADDR_W), .BL_W(BL_W), .OUT_W(OUT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .req_valid(req_valid),
   .req_ready(req_ready), .req_addr(req_addr), .req_beats(req_beats), .rd_done(rd_done),
   .sh_burst(sh_burst), .sh_outst(sh_outst), .outst_cnt(outst_cnt)
);

// File: tb/fb_scan_addrgen_test.sv
module fb_scan_addrgen_test;
   localparam int ADDR_W = 32, LEN_W = 16, CNT_W = 12, BB = 8, MB = 16, MO = 8;
   localparam int BL_W = $clog2(MB + 1), OUT_W = $clog2(MO + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic [ADDR_W-1:0] cfg_base = '0;
   logic [LEN_W-1:0]  cfg_line_len = '0, cfg_line_pitch = '0;
   logic [CNT_W-1:0]  cfg_last_line = '0;
   logic [BL_W-1:0]   cfg_burst_max = '0;
   logic [OUT_W-1:0]  cfg_outst_max = '0;
   logic frame_start = 1'b0, line_start = 1'b0, req_ready = 1'b1, rd_done = 1'b0;
   logic req_valid;
   logic [ADDR_W-1:0] req_addr;
   logic [BL_W-1:0]   req_beats;

   int total = 0, bad = 0, acc_cnt = 0, pend = 0;
   bit done_en = 1'b1;

   always #4 clk = ~clk; // 125 MHz

   fb_scan_addrgen uut (.*);

   always @(posedge clk) begin
      if (req_valid && req_ready) acc_cnt++;
      pend = pend + int'(req_valid && req_ready) - int'(rd_done);
   end
   always @(negedge clk) rd_done <= done_en && (pend > 0);

   task automatic check(string tag, bit ok, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic strobe(bit fs, bit ls);
      @(negedge clk);
      frame_start = fs; line_start = ls;
      @(negedge clk);
      frame_start = 1'b0; line_start = 1'b0;
   endtask

   function automatic int eff_lim(int l);
      return (l == 0 || l > MB) ? MB : l;
   endfunction

   // consume one line from beat start_beat; called at a negedge
   task automatic consume_line(longint base, int len, int lim, int start_beat);
      int total_b = (len + BB - 1) / BB;
      int got = start_beat;
      int guard = 0;
      while (got < total_b && guard < 2000) begin
         if (req_valid) begin
            int exp_b = (total_b - got < eff_lim(lim)) ? total_b - got : eff_lim(lim);
            longint exp_a = base + longint'(got) * BB;
            string tag = (got == 0) ? "R2 addr/beats" : "R3 addr/beats";
            check(tag, req_addr == ADDR_W'(exp_a) && int'(req_beats) == exp_b,
                  {req_addr, 8'(req_beats)}, {exp_a[31:0], 8'(exp_b)});
            got += int'(req_beats);
         end
         guard++;
         @(negedge clk);
      end
      check("R4 beat total", got == total_b, got, total_b);
      check("R4 valid low at line end", !req_valid, req_valid, 0);
   endtask

   task automatic quiet(string tag, int n);
      bit seen = 1'b0;
      repeat (n) begin
         @(negedge clk);
         if (req_valid) seen = 1'b1;
      end
      check(tag, !seen, seen, 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int lims[10] = '{0, 1, 2, 3, 5, 8, 15, 16, 17, 31};
      int lens[11] = '{1, 7, 8, 9, 63, 64, 65, 128, 129, 255, 300};
      int iter = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset valid", !req_valid, req_valid, 0);
      strobe(0, 1);
      quiet("R1 no request before frame", 6);

      // sweep: R2 R3 R4 R5 R6 R11
      foreach (lims[i]) foreach (lens[j]) begin
         longint base = 32'h1000 + iter * 32'h40;
         int pitch = 32'h200 + iter * 4;
         cfg_base = ADDR_W'(base); cfg_line_len = LEN_W'(lens[j]);
         cfg_line_pitch = LEN_W'(pitch); cfg_last_line = 2;
         cfg_burst_max = BL_W'(lims[i]); cfg_outst_max = OUT_W'(MO);
         strobe(1, 0);
         // R6: scramble the inputs inside the frame
         cfg_base = 32'hDEAD0000; cfg_line_len = 16'd999; cfg_line_pitch = 16'd3;
         cfg_last_line = 0; cfg_burst_max = 1; cfg_outst_max = 1;
         for (int ln = 0; ln < 3; ln++) begin
            strobe(0, 1);
            consume_line(base + longint'(ln) * pitch, lens[j], lims[i], 0);
         end
         strobe(0, 1);
         quiet("R5 no fetch past last line", 4);
         iter++;
      end

      // R7 / R8: budget stall, then a stray line strobe
      cfg_base = 32'h8000; cfg_line_len = 256; cfg_line_pitch = 16'h100;
      cfg_last_line = 1; cfg_burst_max = 1; cfg_outst_max = 3;
      strobe(1, 0);
      done_en = 1'b0; acc_cnt = 0;
      strobe(0, 1);
      repeat (12) @(negedge clk);
      check("R7 accepts at limit", acc_cnt == 3, acc_cnt, 3);
      check("R7 valid low at limit", !req_valid, req_valid, 0);
      strobe(0, 1);
      done_en = 1'b1;
      consume_line(32'h8000, 256, 1, 3);
      strobe(0, 1);
      consume_line(32'h8100, 256, 1, 0);
      strobe(0, 1);
      quiet("R5 after directed frame", 6);

      // R10 / R9: held request, frame strobe aborts it
      cfg_base = 32'h9000; cfg_outst_max = 8; cfg_burst_max = 4;
      strobe(1, 0);
      req_ready = 1'b0;
      strobe(0, 1);
      repeat (5) begin
         check("R10 held valid/addr", req_valid && req_addr == 32'h9000, req_addr, 32'h9000);
         @(negedge clk);
      end
      cfg_base = 32'hA000;
      @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      check("R9 frame drops request", !req_valid, req_valid, 0);
      strobe(1, 1);
      quiet("R9 line strobe with frame ignored", 5);
      req_ready = 1'b1;
      strobe(0, 1);
      consume_line(32'hA000, 256, 4, 0);

      repeat (10) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule